// File: doc/BRIEF.md
# GPIO Event Detector and Interrupt Unit

This block watches a resolved GPIO data-in vector, one bit per pin. For each pin it raises a sticky status flag when the pin matches its configured trigger. The trigger can be a high level, a rising edge, or either edge. Software clears a flag by writing a one to it. All flags pass through a per-pin enable mask, and the masked flags are ORed into a single interrupt line.

Configuration goes through a simple register port: one write strobe with address and data, and a separate combinational read address. The enable mask can be written directly. It can also be changed through two alias offsets, one that ORs bits in and one that clears bits. Pin resolution and input debouncing are done upstream, so data-in arrives here already resolved.

Top module: `gpio_evt_unit`

## Requirements
- R1: After synchronous reset, the trigger-type (0x28), edge-select (0x2C), enable (0x40) and status (0x4C) registers all read 0, and `irq` is 0.
- R2: A pin whose trigger-type bit is 0 is in level mode. Its status bit is set on each clock edge that samples its data-in bit at 1. The status bit stays set after data-in returns to 0.
- R3: A pin with trigger-type 1 and edge-select 0 sets its status only when data-in is 1 now and was 0 at the previous clock edge. Falling transitions and steady levels leave its status unchanged.
- R4: A pin with trigger-type 1 and edge-select 1 sets its status on any change of data-in between two consecutive clock edges.
- R5: Writing the status offset (0x4C) clears each status bit written as 1. Status bits written as 0 keep their value.
- R6: In level mode, a clear write to a status bit whose data-in is still 1 has no effect. The bit reads back 1 after the write.
- R7: A write to 0x40 loads the enable mask. A write to 0x44 ORs the written ones into the mask. A write to 0x48 clears the mask bits written as 1. Reads of 0x40, 0x44 and 0x48 all return the mask.
- R8: `irq` is 1 exactly when some bit is set in both status and enable. It reflects an enable change in the cycle after the write edge.
- R9: Dropping a data-in bit back to 0 does not lower `irq`. `irq` falls only after the causing status bit is cleared or its enable bit is cleared.
- R10: Reads of any offset other than the six defined ones return 0. Writes to such offsets leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe for this cycle |
| wr_addr | input | 8 | Byte offset of the register written |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the register read |
| rd_data | output | 32 | Combinational read data for `rd_addr` |
| din | input | 32 | Resolved pin levels, sampled at each clock edge |
| irq | output | 1 | OR of status bits that are enabled |

## Verification
The assertions assume that `din` and the write port are stable around the rising clock edge. They also assume that every input change seen by the edge logic lasts at least one full clock period. The stimulus meets both conditions: it changes inputs only at the falling edge, and it holds every data-in value for at least one whole cycle. The interrupt-hold property also relies on no register write occurring in the cycle it observes. The bench therefore keeps the write strobe low in idle cycles.

// File: rtl/gpio_evt_pkg.sv
// Shared constants for the GPIO event unit: register offsets and
// the address width they decode against.
package gpio_evt_pkg;

    localparam int ADDR_W = 8;

    // Offsets are kept where software decodes them.
    localparam logic [ADDR_W-1:0] OFS_TRIG_TYPE = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_EDGE_SEL  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_MASK      = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_MASK_SET  = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_MASK_CLR  = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_FLAGS     = 8'h4C;

    // Per-pin trigger mode decoded from trigger-type and edge-select bits.
    typedef enum logic [1:0] {
        TRIG_LEVEL  = 2'b00,
        TRIG_RISE   = 2'b10,
        TRIG_ANY    = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/gpio_evt_cfg.sv
// Configuration registers: trigger type, edge select and enable mask,
// plus the write-one-to-clear vector for the status flags.
// Assumes one write per cycle. The status clear vector is combinational,
// valid only in the write cycle.
module gpio_evt_cfg
    import gpio_evt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  trig_type_q,
    output logic [WIDTH-1:0]  edge_sel_q,
    output logic [WIDTH-1:0]  mask_q,
    output logic [WIDTH-1:0]  flag_clr
);

    logic sel_type;
    logic sel_edge;
    logic sel_mask;
    logic sel_set;
    logic sel_clr;
    logic sel_flags;

    // Decode the write address into one strobe per register.
    always_comb begin
        sel_type  = wr_en && (wr_addr == OFS_TRIG_TYPE);
        sel_edge  = wr_en && (wr_addr == OFS_EDGE_SEL);
        sel_mask  = wr_en && (wr_addr == OFS_MASK);
        sel_set   = wr_en && (wr_addr == OFS_MASK_SET);
        sel_clr   = wr_en && (wr_addr == OFS_MASK_CLR);
        sel_flags = wr_en && (wr_addr == OFS_FLAGS);
    end

    // Write-one-to-clear vector handed to the flag logic.
    always_comb begin
        flag_clr = sel_flags ? wr_data : '0;
    end

    // Trigger type register.
    always_ff @(posedge clk) begin
        if (!rst_n)        trig_type_q <= '0;
        else if (sel_type) trig_type_q <= wr_data;
    end

    // Edge select register.
    always_ff @(posedge clk) begin
        if (!rst_n)        edge_sel_q <= '0;
        else if (sel_edge) edge_sel_q <= wr_data;
    end

    // Enable mask with direct, OR-in and clear-out write paths.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '0;
        else if (sel_mask) mask_q <= wr_data;
        else if (sel_set)  mask_q <= mask_q | wr_data;
        else if (sel_clr)  mask_q <= mask_q & ~wr_data;
    end

    AST_MASK_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
        sel_set |=> ((mask_q & $past(wr_data)) == $past(wr_data))); // R7
    AST_MASK_CLR_AND: assert property (@(posedge clk) disable iff (!rst_n)
        sel_clr |=> ((mask_q & $past(wr_data)) == '0)); // R7
    AST_MASK_SET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        sel_set |=> ((mask_q & $past(mask_q)) == $past(mask_q))); // R7

endmodule

// File: rtl/gpio_evt_detect.sv
// Per-pin event detection and sticky status flags.
// Each pin keeps a copy of data-in from the previous edge. The copy is
// reloaded on every clock, reset included, so no edge is invented
// afterwards. Assumes din is synchronous to clk.
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] trig_type,
    input  logic [WIDTH-1:0] edge_sel,
    input  logic [WIDTH-1:0] flag_clr,
    output logic [WIDTH-1:0] flags_q
);

    logic [WIDTH-1:0] prev_din;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        trig_mode_e mode;
        logic       prev_q;
        logic       flag_q;
        logic       hit;

        // Decode this pin's trigger mode; edge select matters only in edge mode.
        always_comb begin
            if (!trig_type[i])    mode = TRIG_LEVEL;
            else if (edge_sel[i]) mode = TRIG_ANY;
            else                  mode = TRIG_RISE;
        end

        // Decide whether the current sample matches the pin's trigger.
        always_comb begin
            unique case (mode)
                TRIG_LEVEL: hit = din[i];
                TRIG_RISE:  hit = din[i] & ~prev_q;
                TRIG_ANY:   hit = din[i] ^ prev_q;
                default:    hit = 1'b0;
            endcase
        end

        // Track the previous sample on every edge, reset included.
        always_ff @(posedge clk) begin
            prev_q <= din[i];
        end

        // Sticky flag: a new hit wins over a same-cycle clear.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= (flag_q & ~flag_clr[i]) | hit;
        end

        assign flags_q[i]  = flag_q;
        assign prev_din[i] = prev_q;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flags_q & ~flag_clr) & ~flags_q) == '0)); // R5
    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(~trig_type & din) & ~flags_q) == '0)); // R6
    AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(trig_type & ~(din ^ prev_din)) & flags_q & ~$past(flags_q)) == '0)); // R3
    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(trig_type & ~edge_sel & ~din) & flags_q & ~$past(flags_q)) == '0)); // R3

endmodule

// File: rtl/gpio_evt_irq.sv
// Interrupt combiner: masks the status flags and ORs them into one line.
// Purely combinational, so a mask change shows on irq as soon as the
// mask register updates.
module gpio_evt_irq #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] flags,
    input  logic [WIDTH-1:0] mask,
    output logic             irq
);

    // Reduce the masked flags to a single request.
    always_comb begin
        irq = |(flags & mask);
    end

endmodule

// File: rtl/gpio_evt_unit.sv
// Top of the GPIO event unit: configuration registers, per-pin detection,
// interrupt combiner and the combinational read mux.
// Assumes din has already been resolved and filtered upstream.
module gpio_evt_unit
    import gpio_evt_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  din,
    output logic              irq
);

    logic [WIDTH-1:0] trig_type_q;
    logic [WIDTH-1:0] edge_sel_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] flag_clr;
    logic [WIDTH-1:0] flags_q;

    gpio_evt_cfg #(.WIDTH(WIDTH)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .trig_type_q (trig_type_q),
        .edge_sel_q  (edge_sel_q),
        .mask_q      (mask_q),
        .flag_clr    (flag_clr)
    );

    gpio_evt_detect #(.WIDTH(WIDTH)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .trig_type (trig_type_q),
        .edge_sel  (edge_sel_q),
        .flag_clr  (flag_clr),
        .flags_q   (flags_q)
    );

    gpio_evt_irq #(.WIDTH(WIDTH)) u_irq (
        .flags (flags_q),
        .mask  (mask_q),
        .irq   (irq)
    );

    // Select the register named by the read address; unmapped reads give 0.
    always_comb begin
        unique case (rd_addr)
            OFS_TRIG_TYPE: rd_data = trig_type_q;
            OFS_EDGE_SEL:  rd_data = edge_sel_q;
            OFS_MASK,
            OFS_MASK_SET,
            OFS_MASK_CLR:  rd_data = mask_q;
            OFS_FLAGS:     rd_data = flags_q;
            default:       rd_data = '0;
        endcase
    end

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq); // R9
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q == '0) |-> !irq); // R8
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R8

endmodule

// File: tb/tb_gpio_evt_unit.sv
module tb_gpio_evt_unit;
    import gpio_evt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [7:0]    wr_addr;
    logic [W-1:0]  wr_data;
    logic [7:0]    rd_addr;
    logic [W-1:0]  rd_data;
    logic [W-1:0]  din;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench-side model of the expected register state.
    logic [W-1:0] m_type, m_edge, m_mask, m_flags, m_prev;

    gpio_evt_unit #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .din(din), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge.
    task automatic step(input bit we, input logic [7:0] a, input logic [W-1:0] d, input logic [W-1:0] dv);
        logic [W-1:0] hit, clr;
        din = dv; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        hit = (~m_type & dv) | (m_type & ~m_edge & dv & ~m_prev) | (m_type & m_edge & (dv ^ m_prev));
        clr = (we && a == OFS_FLAGS) ? d : '0;
        m_flags = (m_flags & ~clr) | hit;
        m_prev = dv;
        if (we) begin
            case (a)
                OFS_TRIG_TYPE: m_type = d;
                OFS_EDGE_SEL:  m_edge = d;
                OFS_MASK:      m_mask = d;
                OFS_MASK_SET:  m_mask = m_mask | d;
                OFS_MASK_CLR:  m_mask = m_mask & ~d;
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_reg(input logic [7:0] a, input logic [W-1:0] exp, input string req);
        rd_addr = a;
        #1;
        check(rd_data === exp, req, rd_data, exp);
    endtask

    task automatic chk_irq(input bit exp, input string req);
        check(irq === exp, req, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic apply_reset(input logic [W-1:0] dv);
        @(negedge clk);
        rst_n = 1'b0; din = dv; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_type = '0; m_edge = '0; m_mask = '0; m_flags = '0; m_prev = dv;
    endtask

    task automatic t_reset;
        apply_reset('0);
        chk_reg(OFS_TRIG_TYPE, '0, "R1");
        chk_reg(OFS_EDGE_SEL, '0, "R1");
        chk_reg(OFS_MASK, '0, "R1");
        chk_reg(OFS_FLAGS, '0, "R1");
        chk_irq(1'b0, "R1");
    endtask

    task automatic t_level;
        logic [W-1:0] d = 32'h5a3c9600;
        step(1, OFS_TRIG_TYPE, '0, d);
        chk_reg(OFS_FLAGS, d, "R2");
        step(0, 8'h00, '0, '0);
        chk_reg(OFS_FLAGS, d, "R2");          // sticky after input falls
        step(1, OFS_FLAGS, 32'h0000ffff, '0);
        chk_reg(OFS_FLAGS, 32'h5a3c0000, "R5");
        step(1, OFS_FLAGS, 32'hffffffff, '0);
        chk_reg(OFS_FLAGS, '0, "R5");
    endtask

    task automatic t_override;
        step(1, OFS_FLAGS, 32'h00000003, 32'h00000001);
        chk_reg(OFS_FLAGS, 32'h00000001, "R6");
        step(1, OFS_FLAGS, 32'h00000001, 32'h00000001);
        chk_reg(OFS_FLAGS, 32'h00000001, "R6");
        step(1, OFS_FLAGS, 32'h00000001, '0);
        chk_reg(OFS_FLAGS, '0, "R6");
    endtask

    task automatic t_rise;
        step(1, OFS_TRIG_TYPE, 32'hffffffff, '0);
        step(1, OFS_EDGE_SEL, '0, 32'hf0f00000);
        step(1, OFS_FLAGS, 32'hffffffff, 32'hf0f00000);
        chk_reg(OFS_FLAGS, '0, "R3");
        step(0, 8'h00, '0, 32'hf00ff000);
        chk_reg(OFS_FLAGS, 32'h000ff000, "R3");
        step(0, 8'h00, '0, 32'h0f000000);
        chk_reg(OFS_FLAGS, 32'h0f0ff000, "R3");
        step(0, 8'h00, '0, 32'h0f000000);
        chk_reg(OFS_FLAGS, m_flags, "R3");
        step(1, OFS_FLAGS, 32'hffffffff, 32'h0f000000);
    endtask

    task automatic t_both;
        step(1, OFS_EDGE_SEL, 32'hffffffff, 32'hf0f00000);
        step(1, OFS_FLAGS, 32'hffffffff, 32'hf0f00000);
        chk_reg(OFS_FLAGS, '0, "R4");
        step(0, 8'h00, '0, 32'hf00ff000);
        chk_reg(OFS_FLAGS, 32'h00fff000, "R4");
        step(0, 8'h00, '0, 32'h0f000000);
        chk_reg(OFS_FLAGS, 32'hfffff000, "R4");
        // mixed per-pin modes against the model
        step(1, OFS_TRIG_TYPE, 32'h0000ff00, 32'h0f000000);
        step(1, OFS_EDGE_SEL, 32'h000000f0, '0);
        step(1, OFS_FLAGS, 32'hffffffff, '0);
        step(0, 8'h00, '0, 32'h0000ffff);
        step(0, 8'h00, '0, 32'h000055aa);
        chk_reg(OFS_FLAGS, m_flags, "R4");
        chk_reg(OFS_FLAGS, 32'h0000ffff, "R4");
    endtask

    task automatic t_mask;
        step(1, OFS_MASK, 32'h00ff00ff, '0);
        chk_reg(OFS_MASK, 32'h00ff00ff, "R7");
        step(1, OFS_MASK_SET, 32'h0f000000, '0);
        chk_reg(OFS_MASK_SET, 32'h0fff00ff, "R7");
        step(1, OFS_MASK_CLR, 32'h000000f0, '0);
        chk_reg(OFS_MASK_CLR, 32'h0fff000f, "R7");
        chk_reg(OFS_MASK, m_mask, "R7");
    endtask

    task automatic t_irq;
        step(1, OFS_TRIG_TYPE, '0, '0);
        step(1, OFS_MASK, '0, '0);
        step(1, OFS_FLAGS, 32'hffffffff, '0);
        chk_irq(1'b0, "R8");
        step(0, 8'h00, '0, 32'h00008000);
        chk_reg(OFS_FLAGS, 32'h00008000, "R8");
        chk_irq(1'b0, "R8");
        step(1, OFS_MASK, 32'hffffffff, '0);
        chk_irq(1'b1, "R8");
        step(0, 8'h00, '0, '0);
        chk_irq(1'b1, "R9");
        step(0, 8'h00, '0, 32'h00000200);
        step(1, OFS_FLAGS, 32'h00008000, 32'h00000200);
        chk_irq(1'b1, "R8");
        step(1, OFS_MASK_CLR, 32'h00000200, 32'h00000200);
        chk_irq(1'b0, "R8");
        step(1, OFS_MASK_SET, 32'h00000200, 32'h00000200);
        chk_irq(1'b1, "R8");
        step(0, 8'h00, '0, '0);
        chk_irq(1'b1, "R9");
        step(1, OFS_FLAGS, 32'h00000200, '0);
        chk_irq(1'b0, "R9");
    endtask

    task automatic t_unmapped;
        step(1, OFS_TRIG_TYPE, 32'h12345678, '0);
        step(1, 8'h30, 32'hffffffff, '0);
        step(1, 8'h4d, 32'hffffffff, '0);
        chk_reg(8'h30, '0, "R10");
        chk_reg(OFS_TRIG_TYPE, 32'h12345678, "R10");
        chk_reg(OFS_EDGE_SEL, m_edge, "R10");
        chk_reg(OFS_MASK, m_mask, "R10");
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; din = '0;
        t_reset();
        t_level();
        t_override();
        t_rise();
        t_both();
        t_mask();
        t_irq();
        t_unmapped();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule